// File: doc/BRIEF.md
# Display Control Status Register

This block sits on the control side of a display engine. It takes 32-bit control words on one port and 32-bit drawing-environment words on another. The command byte of a control word, bits 31:24, selects one of a few actions. These actions are: restore the power-on state, switch blanking, pick the DMA direction, move the display origin, or set the display mode. The block keeps a 32-bit status word built from its own flags and from the environment registers. It also turns the mode field into horizontal and vertical resolution codes that the video-timing logic downstream uses.

The display-mode command does not store its seven parameter bits in one contiguous range. Six of them go to status bits 22:17 and the seventh goes to bit 16. That layout puts the three-bit horizontal code at 18:16 and the two-bit vertical code at 20:19. The low thirteen status bits are not stored in the status register. They are mirrored from two of the eight environment registers, so a drawing-mode or mask word on the environment port shows up in the status word. A separate pair of strobes marks the start and the end of a frame-memory read transfer.

Top module: `disp_status_ctl`

## Requirements
- R1: While `rst_n` is low, and on the edge after a control word with command byte 0x00, the status word becomes 0x14802000, the origin outputs become 0, and each environment register k becomes (0xE0+k) shifted left by 24.
- R2: Command 0x03 sets status bit 23 (blanking) to data bit 0. A 0 in that bit clears the flag.
- R3: Command 0x04 writes data bits 1:0 into status bits 30:29 (DMA direction) and leaves every other status bit alone.
- R4: Command 0x05 loads `disp_x` from data bits 9:0 and `disp_y` from data bits 18:10. The status word does not change.
- R5: Command 0x08 writes data bits 5:0 to status bits 22:17 and data bit 6 to status bit 16. Status bits outside 22:16 do not change.
- R6: `hres_code` always equals status bits 18:16, and `vres_code` always equals status bits 20:19.
- R7: An environment word whose top five bits are 11100 (command byte 0xE0 to 0xE7) is stored in register k = bits 26:24. From the next edge, status bits 10:0 show bits 10:0 of register 1, and status bits 12:11 show bits 1:0 of register 6.
- R8: An environment word with any other command byte changes nothing. A word for a register other than 1 or 6 leaves the status word unchanged.
- R9: Status bit 27 (read transfer active) is set by `rd_xfer_start` and cleared by `rd_xfer_done`. When both are high, start wins. A control reset clears the bit, and reset wins over start.
- R10: A valid control word whose command byte is not 0x00, 0x03, 0x04, 0x05 or 0x08 leaves the status word and the origin unchanged.
- R11: Control and environment writes take effect on the clock edge at which their valid strobe is high. `stat_word` is read combinationally from the stored state, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_valid | input | 1 | Control word strobe |
| ctl_data | input | 32 | Control word: command byte in bits 31:24, parameter below it |
| env_valid | input | 1 | Environment word strobe |
| env_data | input | 32 | Environment word: command byte 0xE0 to 0xE7 selects the register |
| rd_xfer_start | input | 1 | A frame-memory read transfer begins |
| rd_xfer_done | input | 1 | The read transfer ends |
| stat_word | output | 32 | Current status word |
| hres_code | output | 3 | Horizontal resolution index |
| vres_code | output | 2 | Vertical resolution index |
| disp_x | output | 10 | Display origin X |
| disp_y | output | 9 | Display origin Y |

## Verification
On every cycle, the assertions check these behaviours:
- Each single-field command lands in exactly its own status field one edge later.
- A reset command restores the power-on word.
- The read-active flag follows its strobes.
- An unrecognised command leaves status and origin untouched.
- Every environment register keeps its own command byte.

Some behaviours only the bench scenarios can show:
- The full 128-value mode sweep and the scatter arithmetic behind it.
- Mirroring of environment words into the low status bits.
- Rejection of environment words with a foreign command byte.
- The sequence in which a reset command wipes out earlier environment and mode writes.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int WORD_W   = 32;
  localparam int CMD_LSB  = 24;
  localparam int POS_X_W  = 10;
  localparam int POS_Y_W  = 9;
  localparam int MODE_W   = 7;

  localparam logic [WORD_W-1:0] STAT_POWERON = 32'h1480_2000;

  localparam int BIT_RDACT  = 27;
  localparam int BIT_BLANK  = 23;
  localparam int DMA_LSB    = 29;
  localparam int MODE_LSB   = 16;
  localparam int HRES_LSB   = 16;
  localparam int VRES_LSB   = 19;
  localparam int MIRROR_W   = 13;

  typedef enum logic [7:0] {
    OP_RESET  = 8'h00,
    OP_BLANK  = 8'h03,
    OP_DMADIR = 8'h04,
    OP_ORIGIN = 8'h05,
    OP_MODE   = 8'h08
  } ctl_op_e;

  // Mode parameter scatter: p[5:0] -> bits 22:17, p[6] -> bit 16.
  function automatic logic [WORD_W-1:0] mode_scatter(logic [WORD_W-1:0] cur,
                                                     logic [MODE_W-1:0] p);
    logic [WORD_W-1:0] r;
    r = cur;
    r[MODE_LSB +: MODE_W] = {p[5:0], p[6]};
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] env_poweron(int k);
    return {8'(8'hE0 + k), 24'h0};
  endfunction

  // Low status bits mirrored from environment registers 1 and 6.
  function automatic logic [MIRROR_W-1:0] mirror_low(logic [WORD_W-1:0] draw_reg,
                                                      logic [WORD_W-1:0] mask_reg);
    return {mask_reg[1:0], draw_reg[10:0]};
  endfunction
endpackage

// File: rtl/dcs_ctl_decode.sv
module dcs_ctl_decode
  import dcs_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] op,
  output logic       hit_reset,
  output logic       hit_blank,
  output logic       hit_dma,
  output logic       hit_origin,
  output logic       hit_mode,
  output logic       hit_other
);
  always_comb begin
    hit_reset  = 1'b0;
    hit_blank  = 1'b0;
    hit_dma    = 1'b0;
    hit_origin = 1'b0;
    hit_mode   = 1'b0;
    hit_other  = 1'b0;
    if (valid) begin
      case (op)
        OP_RESET:  hit_reset  = 1'b1;
        OP_BLANK:  hit_blank  = 1'b1;
        OP_DMADIR: hit_dma    = 1'b1;
        OP_ORIGIN: hit_origin = 1'b1;
        OP_MODE:   hit_mode   = 1'b1;
        default:   hit_other  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dcs_env_shadow.sv
module dcs_env_shadow
  import dcs_pkg::*;
#(
  parameter int NUM_ENV = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      soft_rst,
  input  logic                      wr_valid,
  input  logic [WORD_W-1:0]         wr_data,
  output logic                      env_hit,
  output logic [NUM_ENV*WORD_W-1:0] env_flat
);
  localparam int IDX_W = (NUM_ENV > 1) ? $clog2(NUM_ENV) : 1;

  assign env_hit = wr_valid && (wr_data[31:27] == 5'b11100);

  for (genvar g = 0; g < NUM_ENV; g++) begin : g_env
    logic [WORD_W-1:0] q;
    logic              sel;
    assign sel = env_hit && (wr_data[CMD_LSB +: IDX_W] == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= env_poweron(g);
      else if (soft_rst) q <= env_poweron(g);
      else if (sel)      q <= wr_data;
    end
    assign env_flat[g*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/dcs_status_core.sv
module dcs_status_core
  import dcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_reset,
  input  logic               hit_blank,
  input  logic               hit_dma,
  input  logic               hit_origin,
  input  logic               hit_mode,
  input  logic [18:0]        param,
  input  logic               rd_start,
  input  logic               rd_done,
  output logic [WORD_W-1:0]  hi_q,
  output logic [POS_X_W-1:0] org_x,
  output logic [POS_Y_W-1:0] org_y
);
  logic [WORD_W-1:0] hi_d;

  always_comb begin
    hi_d = hi_q;
    if (hit_blank) hi_d[BIT_BLANK] = param[0];
    if (hit_dma)   hi_d[DMA_LSB +: 2] = param[1:0];
    if (hit_mode)  hi_d = mode_scatter(hi_q, param[MODE_W-1:0]);
    if (rd_start)      hi_d[BIT_RDACT] = 1'b1;
    else if (rd_done)  hi_d[BIT_RDACT] = 1'b0;
    if (hit_reset) hi_d = STAT_POWERON;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= STAT_POWERON;
      org_x <= '0;
      org_y <= '0;
    end else begin
      hi_q <= hi_d;
      if (hit_reset) begin
        org_x <= '0;
        org_y <= '0;
      end else if (hit_origin) begin
        org_x <= param[POS_X_W-1:0];
        org_y <= param[POS_X_W +: POS_Y_W];
      end
    end
  end
endmodule

// File: rtl/disp_status_ctl.sv
module disp_status_ctl
  import dcs_pkg::*;
#(
  parameter int NUM_ENV = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_valid,
  input  logic [31:0]  ctl_data,
  input  logic         env_valid,
  input  logic [31:0]  env_data,
  input  logic         rd_xfer_start,
  input  logic         rd_xfer_done,
  output logic [31:0]  stat_word,
  output logic [2:0]   hres_code,
  output logic [1:0]   vres_code,
  output logic [9:0]   disp_x,
  output logic [8:0]   disp_y
);
  localparam int ENV_DRAW = 1;
  localparam int ENV_MASK = 6;

  logic hit_reset, hit_blank, hit_dma, hit_origin, hit_mode, hit_other;
  logic env_hit;
  logic [NUM_ENV*WORD_W-1:0] env_flat;
  logic [WORD_W-1:0] hi_q;
  logic [WORD_W-1:0] env_draw, env_mask;

  dcs_ctl_decode u_dec (
    .valid      (ctl_valid),
    .op         (ctl_data[31:24]),
    .hit_reset  (hit_reset),
    .hit_blank  (hit_blank),
    .hit_dma    (hit_dma),
    .hit_origin (hit_origin),
    .hit_mode   (hit_mode),
    .hit_other  (hit_other)
  );

  dcs_env_shadow #(.NUM_ENV(NUM_ENV)) u_env (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (hit_reset),
    .wr_valid (env_valid),
    .wr_data  (env_data),
    .env_hit  (env_hit),
    .env_flat (env_flat)
  );

  dcs_status_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_reset  (hit_reset),
    .hit_blank  (hit_blank),
    .hit_dma    (hit_dma),
    .hit_origin (hit_origin),
    .hit_mode   (hit_mode),
    .param      (ctl_data[18:0]),
    .rd_start   (rd_xfer_start),
    .rd_done    (rd_xfer_done),
    .hi_q       (hi_q),
    .org_x      (disp_x),
    .org_y      (disp_y)
  );

  assign env_draw  = env_flat[ENV_DRAW*WORD_W +: WORD_W];
  assign env_mask  = env_flat[ENV_MASK*WORD_W +: WORD_W];
  assign stat_word = {hi_q[WORD_W-1:MIRROR_W], mirror_low(env_draw, env_mask)};
  assign hres_code = stat_word[HRES_LSB +: 3];
  assign vres_code = stat_word[VRES_LSB +: 2];
endmodule

module disp_status_ctl_chk
  import dcs_pkg::*;
#(
  parameter int NUM_ENV = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [31:0]               ctl_data,
  input logic                      env_valid,
  input logic                      rd_xfer_start,
  input logic                      rd_xfer_done,
  input logic                      hit_reset,
  input logic                      hit_blank,
  input logic                      hit_dma,
  input logic                      hit_mode,
  input logic                      hit_other,
  input logic                      env_hit,
  input logic [NUM_ENV*WORD_W-1:0] env_flat,
  input logic [31:0]               stat_word,
  input logic [9:0]                disp_x,
  input logic [8:0]                disp_y
);
  // R1
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_reset |=> (stat_word == STAT_POWERON) && (disp_x == '0) && (disp_y == '0));
  // R2
  blank_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_blank |=> stat_word[BIT_BLANK] == $past(ctl_data[0]));
  // R3
  dma_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dma |=> stat_word[DMA_LSB +: 2] == $past(ctl_data[1:0]));
  // R5
  mode_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mode |=> stat_word[22:16] == {$past(ctl_data[5:0]), $past(ctl_data[6])});
  // R9
  rd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_xfer_start && !hit_reset) |=> stat_word[BIT_RDACT]);
  // R9
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_xfer_done && !rd_xfer_start) |=> !stat_word[BIT_RDACT]);
  // R10
  other_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_other && !env_valid && !rd_xfer_start && !rd_xfer_done)
      |=> $stable(stat_word) && $stable(disp_x) && $stable(disp_y));
  // R8
  env_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (env_valid && !env_hit) |=> $stable(env_flat));
  // R7
  for (genvar g = 0; g < NUM_ENV; g++) begin : g_tag
    env_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      env_flat[g*WORD_W+24 +: 8] == 8'(8'hE0 + g));
  end
endmodule

bind disp_status_ctl disp_status_ctl_chk #(.NUM_ENV(NUM_ENV)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_data(ctl_data), .env_valid(env_valid),
  .rd_xfer_start(rd_xfer_start), .rd_xfer_done(rd_xfer_done),
  .hit_reset(hit_reset), .hit_blank(hit_blank), .hit_dma(hit_dma),
  .hit_mode(hit_mode), .hit_other(hit_other), .env_hit(env_hit),
  .env_flat(env_flat), .stat_word(stat_word), .disp_x(disp_x), .disp_y(disp_y)
);

// File: tb/disp_status_ctl_tb.sv
module disp_status_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_valid = 1'b0;
  logic [31:0] ctl_data = '0;
  logic        env_valid = 1'b0;
  logic [31:0] env_data = '0;
  logic        rd_xfer_start = 1'b0;
  logic        rd_xfer_done = 1'b0;
  logic [31:0] stat_word;
  logic [2:0]  hres_code;
  logic [1:0]  vres_code;
  logic [9:0]  disp_x;
  logic [8:0]  disp_y;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_stat;
  logic [9:0]  exp_x;
  logic [8:0]  exp_y;
  bit done = 1'b0;

  always #2 clk = ~clk;

  disp_status_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_data(ctl_data),
    .env_valid(env_valid), .env_data(env_data),
    .rd_xfer_start(rd_xfer_start), .rd_xfer_done(rd_xfer_done),
    .stat_word(stat_word), .hres_code(hres_code), .vres_code(vres_code),
    .disp_x(disp_x), .disp_y(disp_y)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  task automatic ctl(logic [31:0] w);
    @(negedge clk); ctl_valid = 1'b1; ctl_data = w;
    @(negedge clk); ctl_valid = 1'b0; ctl_data = '0;
  endtask

  task automatic env(logic [31:0] w);
    @(negedge clk); env_valid = 1'b1; env_data = w;
    @(negedge clk); env_valid = 1'b0; env_data = '0;
  endtask

  task automatic rd(logic s, logic d);
    @(negedge clk); rd_xfer_start = s; rd_xfer_done = d;
    @(negedge clk); rd_xfer_start = 1'b0; rd_xfer_done = 1'b0;
  endtask

  task automatic chk_all(string req);
    chk(req, stat_word, exp_stat);
    chk(req, {22'h0, disp_x}, {22'h0, exp_x});
    chk(req, {23'h0, disp_y}, {23'h0, exp_y});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    exp_stat = 32'h1480_2000; exp_x = '0; exp_y = '0;
    repeat (3) @(negedge clk);
    chk_all("R1 pin reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 blanking, set and clear
    ctl(32'h0300_0000); exp_stat[23] = 1'b0; chk_all("R2 blank clear");
    ctl(32'h03FF_FFFF); exp_stat[23] = 1'b1; chk_all("R2 blank set");

    // R3 all four DMA directions, with stray upper parameter bits
    for (int d = 0; d < 4; d++) begin
      ctl(32'h0400_0000 | 32'h00FF_FFFC | d);
      exp_stat = (exp_stat & ~32'h6000_0000) | (d << 29);
      chk_all("R3 dma dir");
    end

    // R4 origin, including extremes
    for (int k = 0; k < 6; k++) begin
      logic [18:0] p;
      p = (k == 0) ? 19'h0 : (k == 1) ? 19'h7FFFF : 19'(k * 32'h1357B);
      ctl(32'h0500_0000 | {13'h0, p} | 32'h00F8_0000);
      exp_x = p % 1024; exp_y = p / 1024;
      chk_all("R4 origin");
    end

    // R5 and R6 full sweep of the mode parameter
    for (int m = 0; m < 128; m++) begin
      ctl(32'h0800_0000 | 32'h00FF_FF80 | m);
      exp_stat = (exp_stat & ~32'h007F_0000) | ((m & 32'h3F) << 17) | ((m & 32'h40) << 10);
      chk_all("R5 mode scatter");
      chk("R6 hres", {29'h0, hres_code}, (exp_stat >> 16) & 7);
      chk("R6 vres", {30'h0, vres_code}, (exp_stat >> 19) & 3);
    end

    // R7 environment mirroring, R11 next-edge visibility
    env(32'hE1AB_CDEF); exp_stat[10:0] = 11'h5EF; chk_all("R7 env1 mirror");
    env(32'hE600_0003); exp_stat[12:11] = 2'b11; chk_all("R7 env6 mirror");
    env(32'hE600_0001); exp_stat[12:11] = 2'b01; chk_all("R7 env6 update");
    @(negedge clk); env_valid = 1'b1; env_data = 32'hE100_0123;
    chk("R11 not before edge", stat_word, exp_stat);
    @(negedge clk); env_valid = 1'b0;
    exp_stat[10:0] = 11'h123; chk_all("R11 after edge");

    // R8 rejected command bytes and unmirrored registers
    env(32'hD100_07FF); chk_all("R8 foreign byte");
    env(32'hF600_0002); chk_all("R8 foreign byte F6");
    env(32'hE2FF_FFFF); chk_all("R8 env2 no mirror");
    env(32'hE7FF_FFFF); chk_all("R8 env7 no mirror");

    // R9 read-active flag
    rd(1'b1, 1'b0); exp_stat[27] = 1'b1; chk_all("R9 rd start");
    rd(1'b0, 1'b1); exp_stat[27] = 1'b0; chk_all("R9 rd done");
    rd(1'b1, 1'b1); exp_stat[27] = 1'b1; chk_all("R9 start wins");
    rd(1'b0, 1'b1); exp_stat[27] = 1'b0; chk_all("R9 clear again");

    // R10 sweep of every unrecognised command byte
    for (int c = 0; c < 256; c++) begin
      if (c != 8'h00 && c != 8'h03 && c != 8'h04 && c != 8'h05 && c != 8'h08) begin
        ctl((c << 24) | 32'h00FF_FFFF);
        chk_all("R10 unknown cmd");
      end
    end

    // R1 control reset wipes mode, env mirror and read flag; reset beats start
    rd(1'b1, 1'b0); exp_stat[27] = 1'b1;
    @(negedge clk); ctl_valid = 1'b1; ctl_data = 32'h0000_0000; rd_xfer_start = 1'b1;
    @(negedge clk); ctl_valid = 1'b0; rd_xfer_start = 1'b0;
    exp_stat = 32'h1480_2000; exp_x = '0; exp_y = '0;
    chk_all("R1 cmd reset");
    chk("R1 hres after reset", {29'h0, hres_code}, 32'h0);
    chk("R1 vres after reset", {30'h0, vres_code}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule